// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

A watchdog counter for a slow tick domain. A simple word-indexed register bus programs it. The counter counts upward from a programmed load value. A control register can insert a power-of-two prescaler between the slow tick and the counter. When the counter steps past all ones while running, the block emits a one-cycle reset request and restarts from the load value. Software keeps the system alive by writing the trigger register with a value different from the one it wrote last.

The slow domain is modelled as a tick enable, `tick_i`, sampled on the bus clock. Bus writes are posted: each one is captured at once into a shadow register and raises that register's pending flag. The write takes effect on the next tick, and the pending flag then drops. Two-word key sequences, checked in strict order, start and stop the timer. While the timer runs, the counting configuration (control and load) is frozen.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer is stopped, the load and count registers read zero, the status register reads zero and the last trigger value is zero.
- R2: Writing 0x0000BBBB and then 0x00004444 to the sequence register (index 5) starts the timer on the next tick.
- R3: Writing 0x0000AAAA and then 0x00005555 to the sequence register stops the timer on the next tick, after which the count holds.
- R4: A sequence-register write that does not complete a key pair returns the key checker to idle and leaves the run state unchanged; 0xBBBB or 0xAAAA always begins a new pair.
- R5: Status register (index 6) holds one pending flag per register: bit 0 control, bit 2 load, bit 3 trigger, bit 4 sequence. A write sets its flag, and the flag clears on the next tick, when the write takes effect.
- R6: Control register (index 1) bit 5 enables the prescaler and bits 4:2 give the ratio exponent k. When enabled, the counter steps once every 2^k running ticks; otherwise it steps on every running tick.
- R7: While running, the counter increments by one per prescaled step. The count register (index 3) can be read at any time and holds steady while stopped.
- R8: A trigger register (index 4) write whose value differs from the last written value reloads the counter from the load register (index 2) on the next tick. A write of the same value does not reload.
- R9: Control and load writes that are applied while the timer is running are discarded; the read-back value stays unchanged.
- R10: A running step from all ones drives `reset_req_o` high for exactly one clock and reloads the counter from the load register.
- R11: Reading index 0 returns the revision code in bits 7:0 and zero above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow-domain tick enable, one clock wide |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| reset_req_o | output | 1 | One-cycle reset request on counter overflow |

## Verification
Key sequences are driven in correct order, in reverse order, interleaved with stray words, and as a restarted first word. This separates a strictly ordered checker from one that only remembers seeing each key. Counting is tried with the prescaler off and with several ratio exponents, which tells a correct divide-by-2^k from an off-by-one divider. Load values near all ones force wraps, separating overflow reload from trigger reload. Triggers repeat the previous value as well as change it, telling edge-on-change reload apart from reload on every write.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_REV   = 3'd0,
    REG_CTRL  = 3'd1,
    REG_LOAD  = 3'd2,
    REG_COUNT = 3'd3,
    REG_TRIG  = 3'd4,
    REG_SEQ   = 3'd5,
    REG_STAT  = 3'd6
  } reg_idx_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ON1  = 2'd1,
    SEQ_OFF1 = 2'd2
  } seq_st_e;

  localparam logic [15:0] KEY_ON_A  = 16'hBBBB;
  localparam logic [15:0] KEY_ON_B  = 16'h4444;
  localparam logic [15:0] KEY_OFF_A = 16'hAAAA;
  localparam logic [15:0] KEY_OFF_B = 16'h5555;

  localparam int PEND_CTRL = 0;
  localparam int PEND_LOAD = 2;
  localparam int PEND_TRIG = 3;
  localparam int PEND_SEQ  = 4;
endpackage

// File: rtl/kwdt_seq.sv
module kwdt_seq
  import kwdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] key_i,
  output logic              start_o,
  output logic              stop_o
);
  seq_st_e state_q, state_d;
  logic is_on_a, is_on_b, is_off_a, is_off_b;

  assign is_on_a  = key_i == DATA_W'(KEY_ON_A);
  assign is_on_b  = key_i == DATA_W'(KEY_ON_B);
  assign is_off_a = key_i == DATA_W'(KEY_OFF_A);
  assign is_off_b = key_i == DATA_W'(KEY_OFF_B);

  assign start_o = wr_i && (state_q == SEQ_ON1)  && is_on_b;
  assign stop_o  = wr_i && (state_q == SEQ_OFF1) && is_off_b;

  // any write resynchronises; a first key always opens a new pair
  always_comb begin
    state_d = state_q;
    if (wr_i) begin
      if (is_on_a)       state_d = SEQ_ON1;
      else if (is_off_a) state_d = SEQ_OFF1;
      else               state_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  AST_SEQ_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !is_on_a && !is_off_a) |=> state_q == SEQ_IDLE); // R4
  AST_SEQ_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |=> state_q == SEQ_IDLE); // R2
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               clear_i,
  input  logic               en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               step_o
);
  localparam int PRE_W = (1 << RATIO_W) - 1;

  logic [PRE_W-1:0] pre_q, mask;
  logic             done;

  assign mask   = (PRE_W'(1) << ratio_i) - PRE_W'(1);
  assign done   = !en_i || (pre_q == mask);
  assign step_o = run_i && tick_i && done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || clear_i) pre_q <= '0;
    else if (tick_i)            pre_q <= done ? '0 : pre_q + PRE_W'(1);
  end

  AST_PRE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && en_i) |-> pre_q <= mask); // R6
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] count_q;
  logic             wrap_q;
  logic             at_top;

  assign at_top  = &count_q;
  assign count_o = count_q;
  assign wrap_o  = wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= step_i && !reload_i && at_top;
      if (reload_i)    count_q <= load_i;
      else if (step_i) count_q <= at_top ? load_i : count_q + CNT_W'(1);
    end
  end

  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !reload_i) |=> $stable(count_o)); // R7
  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !reload_i && !at_top) |=> count_o == $past(count_o) + CNT_W'(1)); // R7
  AST_RELOAD_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> count_o == $past(load_i)); // R8
  AST_WRAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> count_o == $past(load_i)); // R10
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          CNT_W    = 32,
  parameter int          RATIO_W  = 3,
  parameter logic [7:0]  REV_CODE = 8'h31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              reset_req_o
);
  localparam int CTRL_W  = RATIO_W + 1;
  localparam int CTRL_LO = 2;
  localparam int CTRL_HI = CTRL_LO + CTRL_W - 1;

  logic              run_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_sh;
  logic [CNT_W-1:0]  load_q, load_sh, load_nxt;
  logic [DATA_W-1:0] trig_last_q;
  logic              trig_req_q;
  logic              pend_ctrl, pend_load, pend_trig, pend_seq;
  logic              run_upd_q, run_tgt_q;
  logic              wr_ctrl, wr_load, wr_trig, wr_seq;
  logic              seq_start, seq_stop;
  logic              step, reload;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] stat_w;

  assign wr_ctrl = we_i && (addr_i == REG_CTRL);
  assign wr_load = we_i && (addr_i == REG_LOAD);
  assign wr_trig = we_i && (addr_i == REG_TRIG);
  assign wr_seq  = we_i && (addr_i == REG_SEQ);

  // configuration lands only when the timer was stopped at this tick
  assign load_nxt = (pend_load && !run_q) ? load_sh : load_q;
  assign reload   = tick_i && trig_req_q;

  always_comb begin
    stat_w            = '0;
    stat_w[PEND_CTRL] = pend_ctrl;
    stat_w[PEND_LOAD] = pend_load;
    stat_w[PEND_TRIG] = pend_trig;
    stat_w[PEND_SEQ]  = pend_seq;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      ctrl_q      <= '0;
      ctrl_sh     <= '0;
      load_q      <= '0;
      load_sh     <= '0;
      trig_last_q <= '0;
      trig_req_q  <= 1'b0;
      pend_ctrl   <= 1'b0;
      pend_load   <= 1'b0;
      pend_trig   <= 1'b0;
      pend_seq    <= 1'b0;
      run_upd_q   <= 1'b0;
      run_tgt_q   <= 1'b0;
    end else begin
      if (tick_i) begin
        if (pend_ctrl && !run_q) ctrl_q <= ctrl_sh;
        load_q     <= load_nxt;
        if (run_upd_q) run_q <= run_tgt_q;
        pend_ctrl  <= 1'b0;
        pend_load  <= 1'b0;
        pend_trig  <= 1'b0;
        pend_seq   <= 1'b0;
        trig_req_q <= 1'b0;
        run_upd_q  <= 1'b0;
      end
      if (wr_ctrl) begin
        ctrl_sh   <= wdata_i[CTRL_HI:CTRL_LO];
        pend_ctrl <= 1'b1;
      end
      if (wr_load) begin
        load_sh   <= CNT_W'(wdata_i);
        pend_load <= 1'b1;
      end
      if (wr_trig) begin
        pend_trig   <= 1'b1;
        trig_last_q <= wdata_i;
        if (wdata_i != trig_last_q) trig_req_q <= 1'b1;
      end
      if (wr_seq) begin
        pend_seq <= 1'b1;
        if (seq_start || seq_stop) begin
          run_upd_q <= 1'b1;
          run_tgt_q <= seq_start;
        end
      end
    end
  end

  kwdt_seq #(.DATA_W(DATA_W)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_seq),
    .key_i   (wdata_i),
    .start_o (seq_start),
    .stop_o  (seq_stop)
  );

  kwdt_prescaler #(.RATIO_W(RATIO_W)) i_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .run_i   (run_q),
    .clear_i (reload),
    .en_i    (ctrl_q[CTRL_W-1]),
    .ratio_i (ctrl_q[RATIO_W-1:0]),
    .step_o  (step)
  );

  kwdt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .reload_i (reload),
    .load_i   (load_nxt),
    .count_o  (count),
    .wrap_o   (reset_req_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_REV:   rdata_o[7:0] = REV_CODE;
      REG_CTRL:  rdata_o[CTRL_HI:CTRL_LO] = ctrl_q;
      REG_LOAD:  rdata_o = DATA_W'(load_q);
      REG_COUNT: rdata_o = DATA_W'(count);
      REG_TRIG:  rdata_o = trig_last_q;
      REG_STAT:  rdata_o = stat_w;
      default:   rdata_o = '0;
    endcase
  end

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i) |=> ($stable(load_q) && $stable(ctrl_q))); // R9
  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !we_i) |=> stat_w == '0); // R5
  AST_REQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> ($past(tick_i) && $past(run_q))); // R10
  AST_RUN_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !run_upd_q) |=> !run_q); // R2
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  localparam int DW = 32;
  localparam logic [7:0] REV = 8'h31;
  localparam logic [2:0] A_REV = 0, A_CTRL = 1, A_LOAD = 2, A_CNT = 3,
                         A_TRIG = 4, A_SEQ = 5, A_STAT = 6;

  logic          clk = 0, rst_n = 0, tick = 0, we = 0;
  logic [2:0]    addr = 0;
  logic [DW-1:0] wdata = 0, rdata;
  logic          rreq;
  int            n_chk = 0, n_fail = 0;

  // bench model
  bit        m_run, m_run_upd, m_run_tgt, m_trig_req;
  bit [3:0]  m_ctrl, m_ctrl_sh;
  bit [31:0] m_load, m_load_sh, m_count, m_trig_last;
  bit [4:0]  m_pend;
  int        m_pc, m_seq;
  bit        m_rst;

  always #5 clk = ~clk;

  keyed_wdt #(.REV_CODE(REV)) i_keyed_wdt (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .reset_req_o(rreq));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  function automatic logic [31:0] exp_stat();
    return {27'd0, m_pend[4], m_pend[3], m_pend[2], 1'b0, m_pend[0]};
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
    case (a)
      A_CTRL: begin m_ctrl_sh = d[5:2]; m_pend[0] = 1; end
      A_LOAD: begin m_load_sh = d; m_pend[2] = 1; end
      A_TRIG: begin
        m_pend[3] = 1;
        if (d != m_trig_last) m_trig_req = 1;
        m_trig_last = d;
      end
      A_SEQ: begin
        m_pend[4] = 1;
        if (m_seq == 1 && d == 32'h4444) begin m_run_upd = 1; m_run_tgt = 1; end
        if (m_seq == 2 && d == 32'h5555) begin m_run_upd = 1; m_run_tgt = 0; end
        m_seq = (d == 32'hBBBB) ? 1 : (d == 32'hAAAA) ? 2 : 0;
      end
      default: ;
    endcase
  endtask

  task automatic wr_chk(logic [2:0] a, logic [31:0] d);
    logic [31:0] v;
    wr(a, d);
    rd(A_STAT, v); chk("R5 pending after write", v, exp_stat());
  endtask

  task automatic do_tick();
    logic [31:0] v;
    bit run_old = m_run;
    bit [31:0] mask = (32'd1 << m_ctrl[2:0]) - 1;
    bit step = run_old && (!m_ctrl[3] || m_pc == int'(mask));
    bit reload = m_trig_req;
    if (m_pend[0] && !run_old) m_ctrl = m_ctrl_sh;
    if (m_pend[2] && !run_old) m_load = m_load_sh;
    if (!run_old || reload || step) m_pc = 0; else m_pc++;
    m_rst = 0;
    if (reload) m_count = m_load;
    else if (step) begin
      if (m_count == 32'hFFFF_FFFF) begin m_count = m_load; m_rst = 1; end
      else m_count++;
    end
    if (m_run_upd) m_run = m_run_tgt;
    m_pend = 0; m_trig_req = 0; m_run_upd = 0;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    #1 chk("R10 reset request", {31'd0, rreq}, {31'd0, m_rst});
    rd(A_CNT, v); chk("R7 count", v, m_count);
    rd(A_STAT, v); chk("R5 pending cleared", v, 0);
    if (m_rst) begin
      @(negedge clk); #1 chk("R10 one-cycle pulse", {31'd0, rreq}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] v, c0;
    void'($urandom(32'h1D0C_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 / R11
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_LOAD, v); chk("R1 load", v, 0);
    rd(A_TRIG, v); chk("R1 trigger", v, 0);
    rd(A_REV, v);  chk("R11 revision", v, {24'd0, REV});

    // R8 reload from load
    wr_chk(A_LOAD, 32'h100);
    wr_chk(A_CTRL, 32'h0);
    wr_chk(A_TRIG, 32'h1);
    do_tick();
    rd(A_CNT, v); chk("R8 reload on new trigger", v, 32'h100);
    do_tick();
    rd(A_CNT, v); chk("R7 stopped holds", v, 32'h100);

    // R2 start
    wr_chk(A_SEQ, 32'hBBBB);
    wr_chk(A_SEQ, 32'h4444);
    do_tick();
    do_tick();
    rd(A_CNT, v); chk("R2 started counts", v, 32'h101);

    // R8 same trigger value: no reload
    wr_chk(A_TRIG, 32'h1);
    do_tick();
    rd(A_CNT, v); chk("R8 same trigger no reload", v, 32'h102);

    // R9 frozen while running
    wr_chk(A_LOAD, 32'h55);
    wr_chk(A_CTRL, 32'h3C);
    do_tick();
    rd(A_LOAD, v); chk("R9 load ignored", v, 32'h100);
    rd(A_CTRL, v); chk("R9 ctrl ignored", v, 0);

    // R4 broken / reversed sequences keep running
    wr_chk(A_SEQ, 32'hAAAA);
    wr_chk(A_SEQ, 32'h1234);
    wr_chk(A_SEQ, 32'h5555);
    wr_chk(A_SEQ, 32'h5555);
    wr_chk(A_SEQ, 32'hAAAA);
    wr_chk(A_SEQ, 32'hBBBB);
    wr_chk(A_SEQ, 32'h5555);
    rd(A_CNT, c0);
    do_tick();
    rd(A_CNT, v); chk("R4 bad sequence still running", v, c0 + 1);

    // R3 stop
    wr_chk(A_SEQ, 32'hAAAA);
    wr_chk(A_SEQ, 32'h5555);
    do_tick();
    rd(A_CNT, c0);
    do_tick(); do_tick();
    rd(A_CNT, v); chk("R3 stopped holds", v, c0);

    // R6 prescaler ratio 2 -> divide by 4
    wr_chk(A_CTRL, (32'd1 << 5) | (32'd2 << 2));
    wr_chk(A_LOAD, 32'h40);
    wr_chk(A_TRIG, 32'h2);
    wr_chk(A_SEQ, 32'hBBBB);
    wr_chk(A_SEQ, 32'h4444);
    do_tick();
    repeat (8) do_tick();
    rd(A_CNT, v); chk("R6 divide by four", v, 32'h42);

    // R10 overflow
    wr_chk(A_SEQ, 32'hAAAA);
    wr_chk(A_SEQ, 32'h5555);
    do_tick();
    wr_chk(A_CTRL, 32'h0);
    wr_chk(A_LOAD, 32'hFFFF_FFFE);
    wr_chk(A_TRIG, 32'h3);
    do_tick();
    wr_chk(A_SEQ, 32'hBBBB);
    wr_chk(A_SEQ, 32'h4444);
    do_tick();
    do_tick();
    rd(A_CNT, v); chk("R10 at top", v, 32'hFFFF_FFFF);
    do_tick();
    rd(A_CNT, v); chk("R10 wrap reload", v, 32'hFFFF_FFFE);

    // constrained random
    for (int i = 0; i < 500; i++) begin
      int op = $urandom % 10;
      case (op)
        0: wr_chk(A_LOAD, ($urandom % 2) ? 32'hFFFF_FFFF - ($urandom % 12) : $urandom % 256);
        1: wr_chk(A_CTRL, (($urandom % 2) << 5) | (($urandom % 3) << 2));
        2: wr_chk(A_TRIG, $urandom % 4);
        3, 4: begin
          int k = $urandom % 5;
          wr_chk(A_SEQ, k == 0 ? 32'hBBBB : k == 1 ? 32'h4444 :
                        k == 2 ? 32'hAAAA : k == 3 ? 32'h5555 : $urandom % 65536);
        end
        default: repeat (1 + $urandom % 4) do_tick();
      endcase
    end
    rd(A_LOAD, v); chk("R9 load readback", v, m_load);
    rd(A_CTRL, v); chk("R6 ctrl readback", v, {26'd0, m_ctrl, 2'd0});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule